// File: doc/BRIEF.md
# Serial DAC host controller

This block sits on the host side of a single serial-input digital-to-analog converter and turns parallel codes into timed serial frames. A code arrives on a valid/ready handshake together with a flag that says whether the converter should apply it at the end of the frame or hold it until later. The controller drives an active-low select, a serial clock, a data line and an active-low load strobe. Each frame carries 16 bits, most significant first. A code narrower than the frame is padded with zeros at the least significant end.

The system clock times every pin edge. Seven count inputs hold the minimum length, in system clock cycles, of each interval on the wire: select-to-first-clock setup, clock high phase, clock low phase, last-clock-to-select-release hold, select idle gap, select-release-to-strobe setup and strobe width. A count of zero behaves as one cycle. The data line changes only when the serial clock falls. The clock low phase therefore sets the data setup time, and the clock high phase sets the data hold time. In immediate mode the strobe goes low at the start of the hold interval and stays low across the select rising edge. In deferred mode the strobe stays high for the whole frame, and a separate request input issues the strobe later.

Top module: `dac_serial_host`

## Requirements
- R1: A frame holds select low for exactly 16 rising serial clock edges. The data line holds bit 15 down to bit 0 of the frame word in that order, and each bit is sampled on its rising edge.
- R2: The frame word is the input code in the upper CODE_W bits with zeros in the lower FRAME_W-CODE_W bits (12-bit code 0xA5C is sent as 0xA5C0).
- R3: The first rising clock edge comes exactly max(cfg_cs_setup,1) cycles after select falls, and the serial clock is never high while select is high.
- R4: Every clock high phase lasts max(cfg_sclk_high,1) cycles and every low phase inside a frame lasts max(cfg_sclk_low,1) cycles. The data line never changes while the clock is high.
- R5: Select rises exactly max(cfg_sclk_high,1)+max(cfg_cs_hold,1) cycles after the last rising clock edge.
- R6: After select rises, in_ready returns exactly G cycles later. G is max(cfg_cs_idle,1) in deferred mode and max(cfg_cs_idle,cfg_ld_width,1) in immediate mode.
- R7: in_ready stays low from the accepting edge until the gap ends. in_valid presented while in_ready is low starts no frame.
- R8: In immediate mode (in_defer=0) the strobe falls in the same cycle as the last clock falling edge, is still low when select rises, and rises in the cycle in_ready returns.
- R9: In deferred mode (in_defer=1) the strobe stays high during the frame. A ld_req pulse taken in idle leaves the strobe high for max(cfg_ld_setup,1) cycles and then low for max(cfg_ld_width,1) cycles, with select high throughout. in_ready returns when the strobe rises.
- R10: A strobe request has priority over a new code. A request that arrives in the same cycle as in_valid drops in_ready at once, and the frame follows the strobe. A request that arrives during a frame is held. Its strobe setup interval starts one cycle after that frame's gap ends.
- R11: While reset is applied, select and strobe are high, the serial clock and data are low, and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_cs_setup | input | CTR_W | Select-fall to first rising clock, cycles |
| cfg_sclk_high | input | CTR_W | Clock high phase, cycles |
| cfg_sclk_low | input | CTR_W | Clock low phase, cycles |
| cfg_cs_hold | input | CTR_W | Hold after last high phase before select rises, cycles |
| cfg_cs_idle | input | CTR_W | Minimum select high gap, cycles |
| cfg_ld_setup | input | CTR_W | Deferred strobe setup, cycles |
| cfg_ld_width | input | CTR_W | Strobe low width, cycles |
| in_valid | input | 1 | Code offered |
| in_ready | output | 1 | Controller takes a code on this cycle's edge |
| in_code | input | CODE_W | Code to convert |
| in_defer | input | 1 | 1: hold the code for a later strobe, 0: apply at frame end |
| ld_req | input | 1 | Request one deferred strobe |
| dac_cs_n | output | 1 | Active-low select |
| dac_sclk | output | 1 | Serial clock |
| dac_sdo | output | 1 | Serial data |
| dac_ldac_n | output | 1 | Active-low load strobe |

## Verification
The strobe sequencer and the frame engine share one idle state, so a strobe request and a code offer can fall in the same cycle. The bench raises ld_req and in_valid on the same clock. It expects in_ready to drop at once, the full strobe to run with select high, and the offered code to go out as a complete frame afterwards. A second case raises ld_req in the middle of a deferred frame. It then counts the cycles from the select rising edge to the strobe falling edge, which must equal the gap plus one idle cycle plus the strobe setup.

// File: rtl/dac_host_pkg.sv
package dac_host_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_HIGH   = 3'd2,
    ST_LOW    = 3'd3,
    ST_HOLD   = 3'd4,
    ST_GAP    = 3'd5,
    ST_LSET   = 3'd6,
    ST_LPULSE = 3'd7
  } host_st_e;

endpackage

// File: rtl/dac_phase_timer.sv
// Down-counter that times one wire interval. A loaded count of N keeps
// done low for N-1 cycles; a count of 0 or 1 gives a one-cycle interval.
module dac_phase_timer #(
  parameter int CTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CTR_W-1:0] load_val,
  output logic             done
);

  logic [CTR_W-1:0] cnt_q;
  logic [CTR_W-1:0] cnt_d;
  logic             cnt_en;

  assign done   = (cnt_q <= CTR_W'(1));
  assign cnt_en = load | ~done;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - CTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R4: with no reload, a running interval ends in at most the loaded count
  a_r4_timer_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !done) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/dac_word_shifter.sv
// Holds the padded frame word, presents the current bit and tracks the bit count.
module dac_word_shifter #(
  parameter int CODE_W  = 12,
  parameter int FRAME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  input  logic              shift,
  output logic              sdo,
  output logic              last
);

  localparam int BIT_W = (FRAME_W > 2) ? $clog2(FRAME_W) : 1;
  localparam int PAD_W = FRAME_W - CODE_W;

  logic [FRAME_W-1:0] padded;
  logic [FRAME_W-1:0] sreg_q, sreg_d;
  logic [BIT_W-1:0]   left_q, left_d;
  logic               reg_en;

  generate
    if (PAD_W > 0) begin : g_pad
      assign padded = {code, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign padded = code[CODE_W-1 -: FRAME_W];
    end
  endgenerate

  assign reg_en = load | shift;

  always_comb begin
    if (load) begin
      sreg_d = padded;
      left_d = BIT_W'(FRAME_W - 1);
    end else begin
      sreg_d = {sreg_q[FRAME_W-2:0], 1'b0};
      left_d = left_q - BIT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      left_q <= '0;
    end else if (reg_en) begin
      sreg_q <= sreg_d;
      left_q <= left_d;
    end
  end

  assign sdo  = sreg_q[FRAME_W-1];
  assign last = (left_q == '0);

  // R1: the sequencer never asks for a bit beyond the last one
  a_r1_no_shift_past_last: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> !last);

endmodule

// File: rtl/dac_host_fsm.sv
// Frame and strobe sequencer; all pin levels are registered from the next state.
module dac_host_fsm
  import dac_host_pkg::*;
#(
  parameter int CTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTR_W-1:0] cfg_cs_setup,
  input  logic [CTR_W-1:0] cfg_sclk_high,
  input  logic [CTR_W-1:0] cfg_sclk_low,
  input  logic [CTR_W-1:0] cfg_cs_hold,
  input  logic [CTR_W-1:0] cfg_cs_idle,
  input  logic [CTR_W-1:0] cfg_ld_setup,
  input  logic [CTR_W-1:0] cfg_ld_width,
  input  logic             in_valid,
  input  logic             in_defer,
  input  logic             ld_req,
  input  logic             tmr_done,
  input  logic             bit_last,
  output logic             in_ready,
  output logic             tmr_load,
  output logic [CTR_W-1:0] tmr_val,
  output logic             sh_load,
  output logic             sh_shift,
  output logic             cs_n,
  output logic             sclk,
  output logic             ldac_n
);

  host_st_e   st_q, st_d;
  logic       pend_q, pend_d;
  logic       defer_q, defer_d;
  logic       cs_n_q, sclk_q, ldac_n_q;
  logic       cs_n_d, sclk_d, ldac_n_d;
  logic       start_frame, start_strobe;
  logic [CTR_W-1:0] gap_val;

  assign in_ready     = (st_q == ST_IDLE) & ~pend_q & ~ld_req;
  assign start_frame  = in_ready & in_valid;
  assign start_strobe = (st_q == ST_IDLE) & (pend_q | ld_req);

  // immediate mode stretches the gap so the strobe meets its width
  assign gap_val = (defer_q || (cfg_cs_idle >= cfg_ld_width)) ? cfg_cs_idle : cfg_ld_width;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_strobe) begin
          st_d = ST_LSET;   tmr_load = 1'b1; tmr_val = cfg_ld_setup;
        end else if (start_frame) begin
          st_d = ST_SETUP;  tmr_load = 1'b1; tmr_val = cfg_cs_setup;
          sh_load = 1'b1;
        end
      end
      ST_SETUP, ST_LOW: begin
        if (tmr_done) begin
          st_d = ST_HIGH;   tmr_load = 1'b1; tmr_val = cfg_sclk_high;
        end
      end
      ST_HIGH: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          if (bit_last) begin
            st_d = ST_HOLD; tmr_val = cfg_cs_hold;
          end else begin
            st_d = ST_LOW;  tmr_val = cfg_sclk_low;
            sh_shift = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (tmr_done) begin
          st_d = ST_GAP;    tmr_load = 1'b1; tmr_val = gap_val;
        end
      end
      ST_LSET: begin
        if (tmr_done) begin
          st_d = ST_LPULSE; tmr_load = 1'b1; tmr_val = cfg_ld_width;
        end
      end
      ST_GAP, ST_LPULSE: begin
        if (tmr_done) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    pend_d   = (pend_q | ld_req) & ~start_strobe;
    defer_d  = start_frame ? in_defer : defer_q;
    cs_n_d   = !(st_d == ST_SETUP || st_d == ST_HIGH || st_d == ST_LOW || st_d == ST_HOLD);
    sclk_d   = (st_d == ST_HIGH);
    ldac_n_d = !((st_d == ST_LPULSE) ||
                 (!defer_d && (st_d == ST_HOLD || st_d == ST_GAP)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      pend_q   <= 1'b0;
      defer_q  <= 1'b1;
      cs_n_q   <= 1'b1;
      sclk_q   <= 1'b0;
      ldac_n_q <= 1'b1;
    end else begin
      st_q     <= st_d;
      pend_q   <= pend_d;
      if (start_frame) defer_q <= defer_d;
      cs_n_q   <= cs_n_d;
      sclk_q   <= sclk_d;
      ldac_n_q <= ldac_n_d;
    end
  end

  assign cs_n   = cs_n_q;
  assign sclk   = sclk_q;
  assign ldac_n = ldac_n_q;

  // R3: serial clock only toggles inside a selected frame
  a_r3_sclk_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> !cs_n_q);

  // R7: no new code is taken while a frame is on the wire
  a_r7_busy_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_q |-> !in_ready);

  // R9: a deferred frame never strobes the converter
  a_r9_defer_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_q && defer_q) |-> ldac_n_q);

  // R10: while a strobe is low with select high, no frame may open
  a_r10_strobe_before_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (!ldac_n_q && cs_n_q) |=> cs_n_q);

endmodule

// File: rtl/dac_serial_host.sv
module dac_serial_host #(
  parameter int CTR_W   = 8,
  parameter int CODE_W  = 12,
  parameter int FRAME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTR_W-1:0]  cfg_cs_setup,
  input  logic [CTR_W-1:0]  cfg_sclk_high,
  input  logic [CTR_W-1:0]  cfg_sclk_low,
  input  logic [CTR_W-1:0]  cfg_cs_hold,
  input  logic [CTR_W-1:0]  cfg_cs_idle,
  input  logic [CTR_W-1:0]  cfg_ld_setup,
  input  logic [CTR_W-1:0]  cfg_ld_width,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  input  logic              in_defer,
  input  logic              ld_req,
  output logic              dac_cs_n,
  output logic              dac_sclk,
  output logic              dac_sdo,
  output logic              dac_ldac_n
);

  logic [1:0]       rst_sync_q;
  logic             core_rst_n;
  logic             tmr_load, tmr_done;
  logic [CTR_W-1:0] tmr_val;
  logic             sh_load, sh_shift, bit_last;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  dac_host_fsm #(.CTR_W(CTR_W)) i_fsm (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .cfg_cs_setup (cfg_cs_setup),
    .cfg_sclk_high(cfg_sclk_high),
    .cfg_sclk_low (cfg_sclk_low),
    .cfg_cs_hold  (cfg_cs_hold),
    .cfg_cs_idle  (cfg_cs_idle),
    .cfg_ld_setup (cfg_ld_setup),
    .cfg_ld_width (cfg_ld_width),
    .in_valid     (in_valid),
    .in_defer     (in_defer),
    .ld_req       (ld_req),
    .tmr_done     (tmr_done),
    .bit_last     (bit_last),
    .in_ready     (in_ready),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .sh_load      (sh_load),
    .sh_shift     (sh_shift),
    .cs_n         (dac_cs_n),
    .sclk         (dac_sclk),
    .ldac_n       (dac_ldac_n)
  );

  dac_phase_timer #(.CTR_W(CTR_W)) i_timer (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .done    (tmr_done)
  );

  dac_word_shifter #(.CODE_W(CODE_W), .FRAME_W(FRAME_W)) i_shifter (
    .clk  (clk),
    .rst_n(core_rst_n),
    .load (sh_load),
    .code (in_code),
    .shift(sh_shift),
    .sdo  (dac_sdo),
    .last (bit_last)
  );

endmodule

// File: tb/test_dac_serial_host.sv
module test_dac_serial_host;

  localparam int CLK_PERIOD = 10;
  localparam int CW      = 8;
  localparam int CODE_W  = 12;
  localparam int FRAME_W = 16;
  localparam int PAD_W   = FRAME_W - CODE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_defer = 1'b0, ld_req = 1'b0;
  logic [CODE_W-1:0] in_code = '0;
  logic in_ready, dac_cs_n, dac_sclk, dac_sdo, dac_ldac_n;
  int c_setup, c_hi, c_lo, c_hold, c_idle, c_lds, c_ldw;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_serial_host #(.CTR_W(CW), .CODE_W(CODE_W), .FRAME_W(FRAME_W)) i_dac_serial_host (
    .clk(clk), .rst_n(rst_n),
    .cfg_cs_setup(c_setup[CW-1:0]), .cfg_sclk_high(c_hi[CW-1:0]),
    .cfg_sclk_low(c_lo[CW-1:0]), .cfg_cs_hold(c_hold[CW-1:0]),
    .cfg_cs_idle(c_idle[CW-1:0]), .cfg_ld_setup(c_lds[CW-1:0]),
    .cfg_ld_width(c_ldw[CW-1:0]),
    .in_valid(in_valid), .in_ready(in_ready), .in_code(in_code),
    .in_defer(in_defer), .ld_req(ld_req),
    .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk), .dac_sdo(dac_sdo),
    .dac_ldac_n(dac_ldac_n)
  );

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int mx1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int gap_len(input bit defer);
    if (defer) return mx1(c_idle);
    return mx1((c_ldw > c_idle) ? c_ldw : c_idle);
  endfunction

  typedef struct packed {
    logic [FRAME_W-1:0] word;
    logic               defer;
  } exp_t;

  exp_t sb_q[$];
  int   pushed = 0, frames_done = 0;
  bit   skip_gap = 1'b0, mon_en = 1'b0;

  // monitor: decodes frames from the pins and compares with the scoreboard
  initial begin
    int idx = 0, nbits = 0;
    int t_csfall = 0, t_rise = 0, t_fall = 0, t_csrise = 0;
    logic p_cs = 1'b1, p_sclk = 1'b0, p_sdo = 1'b0, p_ldac = 1'b1;
    bit in_frame = 1'b0, wait_gap = 1'b0;
    logic [FRAME_W-1:0] word = '0;
    exp_t cur = '0;
    forever begin
      @(negedge clk);
      if (mon_en) begin
        idx++;
        if (p_cs && !dac_cs_n) begin
          in_frame = 1'b1; nbits = 0; t_csfall = idx; word = '0;
          if (sb_q.size() == 0) begin
            chk(1'b0, "R7 frame without accepted code", 1, 0);
            cur = '0;
          end else cur = sb_q.pop_front();
        end
        if (!p_sclk && dac_sclk) begin
          if (nbits == 0) chk(idx - t_csfall == mx1(c_setup), "R3 cs setup", idx - t_csfall, mx1(c_setup));
          else            chk(idx - t_fall == mx1(c_lo), "R4 low phase", idx - t_fall, mx1(c_lo));
          word = {word[FRAME_W-2:0], dac_sdo};
          nbits++; t_rise = idx;
        end
        if (p_sclk && !dac_sclk) begin
          chk(idx - t_rise == mx1(c_hi), "R4 high phase", idx - t_rise, mx1(c_hi));
          t_fall = idx;
        end
        if (in_frame && p_sclk && dac_sclk && (dac_sdo != p_sdo))
          chk(1'b0, "R4 data moved while clock high", dac_sdo, p_sdo);
        if (in_frame && p_ldac && !dac_ldac_n) begin
          if (cur.defer) chk(1'b0, "R9 strobe inside deferred frame", 0, 1);
          else chk(idx == t_fall, "R8 strobe falls with last clock fall", idx, t_fall);
        end
        if (in_frame && in_ready) chk(1'b0, "R7 ready inside frame", 1, 0);
        if (!p_cs && dac_cs_n) begin
          chk(nbits == FRAME_W, "R1 bit count", nbits, FRAME_W);
          chk(word == cur.word, "R1 R2 frame word", word, cur.word);
          chk(idx - t_rise == mx1(c_hi) + mx1(c_hold), "R5 cs hold",
              idx - t_rise, mx1(c_hi) + mx1(c_hold));
          if (!cur.defer) chk(!dac_ldac_n, "R8 strobe low across cs rise", dac_ldac_n, 0);
          t_csrise = idx; in_frame = 1'b0; frames_done++;
          wait_gap = !skip_gap;
        end else if (wait_gap && in_ready) begin
          chk(idx - t_csrise == gap_len(cur.defer), "R6 cs gap", idx - t_csrise, gap_len(cur.defer));
          if (!cur.defer) chk(!p_ldac && dac_ldac_n, "R8 strobe rises with ready", dac_ldac_n, 1);
          wait_gap = 1'b0;
        end
        p_cs = dac_cs_n; p_sclk = dac_sclk; p_sdo = dac_sdo; p_ldac = dac_ldac_n;
      end
    end
  end

  // driver: offer one code, record the expected frame
  task automatic send(input logic [CODE_W-1:0] code, input bit defer);
    exp_t e;
    do @(negedge clk); while (!in_ready);
    in_valid = 1'b1; in_code = code; in_defer = defer;
    e.word = {code, {PAD_W{1'b0}}}; e.defer = defer;
    sb_q.push_back(e); pushed++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(in_ready && frames_done == pushed));
  endtask

  // counts strobe high/low samples after the current negedge, checks select stays high
  task automatic measure_strobe(input int exp_hi, input string tag);
    int hi_n = 0, lo_n = 0;
    bit cs_ok = 1'b1;
    while (dac_ldac_n) begin hi_n++; cs_ok &= dac_cs_n; @(negedge clk); end
    while (!dac_ldac_n) begin lo_n++; cs_ok &= dac_cs_n; @(negedge clk); end
    chk(hi_n == exp_hi, {tag, " strobe setup"}, hi_n, exp_hi);
    chk(lo_n == mx1(c_ldw), {tag, " strobe width"}, lo_n, mx1(c_ldw));
    chk(cs_ok, {tag, " select high during strobe"}, cs_ok, 1);
    chk(in_ready, {tag, " ready after strobe"}, in_ready, 1);
  endtask

  task automatic set_cfg(input int s, h, l, d, g, ls, lw);
    c_setup = s; c_hi = h; c_lo = l; c_hold = d; c_idle = g; c_lds = ls; c_ldw = lw;
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    set_cfg(2, 2, 3, 1, 4, 2, 3);
    repeat (3) @(negedge clk);
    // R11: reset levels
    chk(dac_cs_n == 1'b1, "R11 cs_n in reset", dac_cs_n, 1);
    chk(dac_sclk == 1'b0, "R11 sclk in reset", dac_sclk, 0);
    chk(dac_sdo == 1'b0, "R11 sdo in reset", dac_sdo, 0);
    chk(dac_ldac_n == 1'b1, "R11 ldac_n in reset", dac_ldac_n, 1);
    chk(in_ready == 1'b1, "R11 ready in reset", in_ready, 1);
    rst_n = 1'b1;
    mon_en = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2 R8: immediate frames, then deferred
    send(12'hA5C, 1'b0);
    send(12'h3F1, 1'b1);
    wait_idle();

    // R9: deferred strobe request from idle
    ld_req = 1'b1;
    @(negedge clk);
    ld_req = 1'b0;
    measure_strobe(mx1(c_lds), "R9");

    // R7: code offered while busy is ignored
    send(12'h0F0, 1'b0);
    in_valid = 1'b1; in_code = 12'hBAD; in_defer = 1'b0;
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
    wait_idle();
    chk(frames_done == pushed, "R7 frames sent match codes taken", frames_done, pushed);

    // R10: strobe request and code offer in the same cycle
    begin
      exp_t e;
      do @(negedge clk); while (!in_ready);
      ld_req = 1'b1; in_valid = 1'b1; in_code = 12'h5A5; in_defer = 1'b1;
      #1;
      chk(!in_ready, "R10 ready drops for strobe request", in_ready, 0);
      @(negedge clk);
      ld_req = 1'b0;
      measure_strobe(mx1(c_lds), "R10");
      e.word = {12'h5A5, {PAD_W{1'b0}}}; e.defer = 1'b1;
      sb_q.push_back(e); pushed++;
      @(negedge clk);
      in_valid = 1'b0;
      wait_idle();
    end

    // R10: request during a deferred frame is held until the gap ends
    send(12'h777, 1'b1);
    skip_gap = 1'b1;
    ld_req = 1'b1;
    @(negedge clk);
    ld_req = 1'b0;
    while (!dac_cs_n) @(negedge clk);
    measure_strobe(mx1(c_idle) + 1 + mx1(c_lds), "R10 held");
    skip_gap = 1'b0;
    wait_idle();

    // boundary: all counts zero behave as one cycle
    set_cfg(0, 0, 0, 0, 0, 0, 0);
    send(12'hFFF, 1'b0);
    send(12'h001, 1'b1);
    wait_idle();
    ld_req = 1'b1;
    @(negedge clk);
    ld_req = 1'b0;
    measure_strobe(1, "R9 zero counts");

    // R6 R8: strobe width longer than idle stretches the immediate gap
    set_cfg(1, 1, 1, 5, 2, 3, 7);
    send(12'h800, 1'b0);
    send(12'h7FF, 1'b0);
    send(12'h123, 1'b1);
    wait_idle();
    chk(frames_done == pushed, "R1 all frames seen", frames_done, pushed);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule